// File: doc/BRIEF.md
# Register-Mapped SPI Host Controller

This block sits on a simple single-cycle register port and drives an SPI bus as its master. Software configures clock mode, bit rate, chip-select behaviour and an inter-byte delay. It then writes bytes into a transmit FIFO. A serial engine shifts each byte out on MOSI, most significant bit first, while it samples MISO. Every received byte goes into a receive FIFO, which software drains through a data register. Words are always 8 bits wide, and the controller only ever acts as master.

The serial engine is a three-state machine:
- ENG_IDLE waits for permission to launch a byte.
- ENG_SHIFT produces sixteen SCLK edges, one every half period.
- ENG_GAP counts the programmed inter-byte delay.

The transitions are:
- ENG_IDLE to ENG_SHIFT (launch). This fires when the controller is enabled, the transmit FIFO holds data, and either automatic start is selected or a manual start is pending.
- ENG_SHIFT to ENG_SHIFT (back-to-back reload). This happens when the delay is zero and another byte is ready.
- ENG_SHIFT to ENG_GAP (byte done, delay non-zero).
- ENG_SHIFT to ENG_IDLE (byte done with nothing to send, or controller disabled).
- ENG_GAP to ENG_SHIFT (delay expired and another byte is ready).
- ENG_GAP to ENG_IDLE (delay expired with nothing ready, or controller disabled).

Register map (byte addresses), used by every requirement below:

| Address | Register |
|---|---|
| 0x00 | configuration |
| 0x14 | enable (bit 0) |
| 0x18 | inter-byte delay, in reference clocks |
| 0x1C | transmit data |
| 0x20 | receive data |
| 0x24 | slave idle count |
| 0x28 | transmit watermark |

Configuration fields:

| Bits | Field |
|---|---|
| 0 | master |
| 1 | CPOL |
| 2 | CPHA |
| [5:3] | divisor code n |
| 9 | decoded-select flag |
| [13:10] | select field |
| 14 | forced select |
| 15 | manual-start mode |
| 16 | start trigger |

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the configuration reads 0x7C09 (master, code 1, select field 1111, forced select), enable reads 0, SCLK is 0 and all four selects are high.
- R2: Each SCLK half period lasts 1<<n reference clocks for divisor code n in 1..7; code 0 behaves as code 1.
- R3: In all four CPOL/CPHA modes, SCLK idles at CPOL and MOSI sends MSB first. With CPHA=0, data is valid at the leading edge; with CPHA=1, at the trailing edge.
- R4: A CPOL/CPHA change takes effect only when the enable bit is written from 0 to 1.
- R5: Each byte shifted out pushes exactly one byte, sampled from MISO, into the receive FIFO.
- R6: Reading receive data while the receive FIFO is empty returns 0 and does not consume a later byte.
- R7: A transmit-data write while the transmit FIFO is full is dropped.
- R8: With enable 0 the engine stays idle and SCLK does not toggle, even if bytes are queued. With enable 1 and automatic start, queued bytes are sent without further action.
- R9: In manual-start mode no byte is launched until a write sets configuration bit 16. That bit reads back as 0, and the start holds until the transmit FIFO is empty.
- R10: The time between the last edge of one byte and the first edge of the next is one half period plus the delay register value. A value of 0 gives back-to-back bytes.
- R11: With forced select, the four select lines always equal the select field. Otherwise they equal the field while the engine is busy and 1111 while it is idle. The field is passed unchanged in both one-hot and decoded (bit 9) use.
- R12: Delay, slave idle count and watermark registers read back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (pops receive data) |
| reg_addr | input | 6 | register byte address |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, valid in the cycle of reg_rd |
| miso | input | 1 | serial data from the device |
| sclk | output | 1 | serial clock |
| mosi | output | 1 | serial data to the device |
| ss_n | output | 4 | chip-select lines |

## Verification
The bench builds the controller with FIFO_DEPTH=16, so both the transmit overflow and a full receive drain are reached within a few hundred cycles. The delay and idle-count widths stay at 8 bits. The divisor is swept across codes 0, 1, 3 and 7, which brings both the smallest and the largest half period within reach. A loopback with optional inversion on MISO separates the sampled data from the transmitted data in the mode checks.

// File: rtl/shc_pkg.sv
package shc_pkg;
    localparam logic [5:0] A_CFG   = 6'h00;
    localparam logic [5:0] A_EN    = 6'h14;
    localparam logic [5:0] A_DLY   = 6'h18;
    localparam logic [5:0] A_TXD   = 6'h1C;
    localparam logic [5:0] A_RXD   = 6'h20;
    localparam logic [5:0] A_IDLE  = 6'h24;
    localparam logic [5:0] A_WMARK = 6'h28;

    localparam logic [15:0] CFG_RESET = 16'h7C09;
    localparam logic [15:0] CFG_MASK  = 16'hFE3F;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_GAP   = 2'd2
    } eng_state_t;
endpackage

// File: rtl/shc_fifo.sv
module shc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full) mem[wp[AW-1:0]] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end

    // R7: a push into a full FIFO leaves the write pointer where it was
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |=> $stable(wp));
    // R6: a pop from an empty FIFO leaves the read pointer where it was
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop) |=> $stable(rp));
endmodule

// File: rtl/shc_engine.sv
module shc_engine
    import shc_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [2:0]       div_code,
    input  logic [DLY_W-1:0] gap_len,
    input  logic             go,
    input  logic [7:0]       tx_byte,
    output logic             tx_pop,
    output logic [7:0]       rx_byte,
    output logic             rx_push,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             busy
);
    localparam int HCW = 8;

    eng_state_t       state, state_nx;
    logic [HCW-1:0]   hcnt, half_m1;
    logic [8:0]       half_full;
    logic [3:0]       edge_n;
    logic [DLY_W-1:0] gcnt;
    logic [7:0]       sh;
    logic             cap, phase;
    logic [2:0]       code_eff;
    logic             tick, last, samp, shft, load;

    assign code_eff  = (div_code == 3'd0) ? 3'd1 : div_code;
    assign half_full = 9'd1 << code_eff;
    assign half_m1   = half_full[7:0] - 8'd1;
    assign tick = (state == ENG_SHIFT) && (hcnt == half_m1);
    assign last = tick && (edge_n == 4'd15);
    assign samp = tick && (cpha ? edge_n[0] : !edge_n[0]);
    assign shft = tick && (cpha ? (!edge_n[0] && edge_n != 4'd0) : edge_n[0]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_nx;
    end

    // next state and control outputs
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ENG_IDLE: begin
                if (go) begin
                    load     = 1'b1;
                    state_nx = ENG_SHIFT;
                end
            end
            ENG_SHIFT: begin
                if (!en) state_nx = ENG_IDLE;
                else if (last) begin
                    if (gap_len == '0) begin
                        if (go) load = 1'b1;
                        else    state_nx = ENG_IDLE;
                    end else begin
                        state_nx = ENG_GAP;
                    end
                end
            end
            ENG_GAP: begin
                if (!en) state_nx = ENG_IDLE;
                else if (gcnt == gap_len - DLY_W'(1)) begin
                    if (go) begin
                        load     = 1'b1;
                        state_nx = ENG_SHIFT;
                    end else begin
                        state_nx = ENG_IDLE;
                    end
                end
            end
            default: state_nx = ENG_IDLE;
        endcase
    end

    assign tx_pop  = load;
    assign rx_push = last && en;
    assign rx_byte = cpha ? {sh[6:0], miso} : {sh[6:0], cap};
    assign busy    = (state != ENG_IDLE);
    assign mosi    = sh[7];
    assign sclk    = cpol ^ phase;

    // shifter, edge and delay counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            cap    <= 1'b0;
            phase  <= 1'b0;
            hcnt   <= '0;
            edge_n <= '0;
            gcnt   <= '0;
        end else begin
            if (load) begin
                sh     <= tx_byte;
                hcnt   <= '0;
                edge_n <= '0;
                phase  <= 1'b0;
            end else if (state == ENG_SHIFT) begin
                if (tick) begin
                    hcnt   <= '0;
                    edge_n <= edge_n + 4'd1;
                    phase  <= ~phase;
                    if (samp) cap <= miso;
                    if (shft) sh  <= {sh[6:0], cap};
                end else begin
                    hcnt <= hcnt + 8'd1;
                end
            end
            if (state_nx != ENG_SHIFT) phase <= 1'b0;
            if (state == ENG_GAP) gcnt <= gcnt + DLY_W'(1);
            else                  gcnt <= '0;
        end
    end

    // R8: a disabled controller leaves the engine idle on the next cycle
    a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ENG_IDLE));
    // R2: SCLK moves only on a half-period boundary
    a_r2_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_SHIFT && en && !tick) |=> $stable(phase));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import shc_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int DLY_W      = 8,
    parameter int IDLE_W     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        miso,
    output logic        sclk,
    output logic        mosi,
    output logic [3:0]  ss_n
);
    localparam int WM_W = $clog2(FIFO_DEPTH) + 1;

    logic [15:0]       cfg_q;
    logic              en_q, cpol_l, cpha_l, start_pend;
    logic [DLY_W-1:0]  dly_q;
    logic [IDLE_W-1:0] idle_q;
    logic [WM_W-1:0]   wm_q;

    logic       tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0] tx_dout, rx_dout, rx_byte;
    logic       tx_pop, rx_push, eng_busy, go;
    logic       wr_cfg, wr_en, wr_txd, rd_rxd;

    assign wr_cfg = reg_wr && (reg_addr == A_CFG);
    assign wr_en  = reg_wr && (reg_addr == A_EN);
    assign wr_txd = reg_wr && (reg_addr == A_TXD);
    assign rd_rxd = reg_rd && (reg_addr == A_RXD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= CFG_RESET;
            en_q       <= 1'b0;
            cpol_l     <= 1'b0;
            cpha_l     <= 1'b0;
            start_pend <= 1'b0;
            dly_q      <= '0;
            idle_q     <= '0;
            wm_q       <= '0;
        end else begin
            if (wr_cfg) cfg_q <= reg_wdata[15:0] & CFG_MASK;
            if (wr_en) begin
                en_q <= reg_wdata[0];
                if (reg_wdata[0] && !en_q) begin
                    cpol_l <= cfg_q[1];
                    cpha_l <= cfg_q[2];
                end
            end
            if (wr_cfg && reg_wdata[15] && reg_wdata[16]) start_pend <= 1'b1;
            else if (!eng_busy && tx_empty)               start_pend <= 1'b0;
            if (reg_wr && reg_addr == A_DLY)   dly_q  <= reg_wdata[DLY_W-1:0];
            if (reg_wr && reg_addr == A_IDLE)  idle_q <= reg_wdata[IDLE_W-1:0];
            if (reg_wr && reg_addr == A_WMARK) wm_q   <= reg_wdata[WM_W-1:0];
        end
    end

    always_comb begin
        case (reg_addr)
            A_CFG:   reg_rdata = {16'd0, cfg_q};
            A_EN:    reg_rdata = {31'd0, en_q};
            A_DLY:   reg_rdata = 32'(dly_q);
            A_RXD:   reg_rdata = rx_empty ? 32'd0 : {24'd0, rx_dout};
            A_IDLE:  reg_rdata = 32'(idle_q);
            A_WMARK: reg_rdata = 32'(wm_q);
            default: reg_rdata = 32'd0;
        endcase
    end

    assign go   = en_q && !tx_empty && (!cfg_q[15] || start_pend);
    assign ss_n = (cfg_q[14] || eng_busy) ? cfg_q[13:10] : 4'hF;

    shc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_txd), .din(reg_wdata[7:0]),
        .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full));

    shc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rd_rxd), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

    shc_engine #(.DLY_W(DLY_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(en_q), .cpol(cpol_l), .cpha(cpha_l),
        .div_code(cfg_q[5:3]), .gap_len(dly_q), .go(go), .tx_byte(tx_dout),
        .tx_pop(tx_pop), .rx_byte(rx_byte), .rx_push(rx_push), .miso(miso),
        .sclk(sclk), .mosi(mosi), .busy(eng_busy));

    // R9: in manual-start mode with no start pending, an idle engine stays idle
    a_r9_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[15] && !start_pend && !eng_busy) |=> !eng_busy);
    // R7: the transmit FIFO never reports full and empty together
    a_r7_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));
    // R5: a receive push never meets a full receive FIFO while it is also empty
    a_r5_rx_sane: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full && rx_empty));
endmodule

// File: tb/spi_host_ctrl_tb_top.sv
module spi_host_ctrl_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        miso, sclk, mosi;
    logic [3:0]  ss_n;
    logic        miso_inv = 1'b0;

    int n_chk = 0, n_err = 0;
    logic [7:0] exp_mosi[$];
    logic [7:0] rx_exp[$];

    logic mon_cpol = 1'b0, mon_cpha = 1'b0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;
    logic [7:0] bits = '0;
    int nb = 0, tog = 0, cyc = 0, last_cyc = 0, min_iv = 9999, max_iv = 0;
    bit first = 1'b1;

    always #10 clk = ~clk;
    assign miso = miso_inv ? ~mosi : mosi;

    spi_host_ctrl #(.FIFO_DEPTH(DEPTH), .DLY_W(8), .IDLE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .miso(miso), .sclk(sclk), .mosi(mosi), .ss_n(ss_n));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: device-side view of the bus, scoreboarding MOSI bytes
    always @(negedge clk) begin
        cyc++;
        if (rst_n && sclk !== prev_sclk) begin
            tog++;
            if (!first) begin
                if (cyc - last_cyc < min_iv) min_iv = cyc - last_cyc;
                if (cyc - last_cyc > max_iv) max_iv = cyc - last_cyc;
            end
            first = 1'b0;
            last_cyc = cyc;
            if ((prev_sclk == mon_cpol) != mon_cpha) begin
                bits = {bits[6:0], prev_mosi};
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    if (exp_mosi.size() == 0) chk("R3 unexpected byte", {24'd0, bits}, 32'hFFFF_FFFF);
                    else chk("R3 mosi byte", {24'd0, bits}, {24'd0, exp_mosi.pop_front()});
                end
            end
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
    end

    task automatic mon_reset();
        @(posedge clk); #1;
        nb = 0; tog = 0; first = 1'b1; min_iv = 9999; max_iv = 0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    // driver: queue a byte and its expected bus and receive values
    task automatic send(input logic [7:0] b);
        wr(6'h1C, {24'd0, b});
        exp_mosi.push_back(b);
        rx_exp.push_back(miso_inv ? ~b : b);
    endtask

    task automatic readback(input int n, input string tag);
        logic [31:0] v;
        for (int i = 0; i < n; i++) begin
            rd(6'h20, v);
            chk(tag, v, {24'd0, rx_exp.pop_front()});
        end
    endtask

    task automatic wait_tog(input int n);
        int k = 0;
        while (tog < n && k < 40000) begin
            @(negedge clk); k++;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic set_mode(input logic p, input logic h);
        wr(6'h14, 0);
        wr(6'h00, 32'h3809 | {29'd0, h, p, 1'b0});
        wr(6'h14, 1);
        mon_cpol = p; mon_cpha = h;
        repeat (3) @(negedge clk);
        mon_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(6'h00, v); chk("R1 cfg reset", v, 32'h7C09);
        rd(6'h14, v); chk("R1 enable reset", v, 0);
        chk("R1 sclk reset", {31'd0, sclk}, 0);
        chk("R1 ss reset", {28'd0, ss_n}, 32'hF);
        // R12 plain registers
        wr(6'h18, 5);    rd(6'h18, v); chk("R12 delay", v, 5);
        wr(6'h24, 8'h3C); rd(6'h24, v); chk("R12 idle count", v, 32'h3C);
        wr(6'h28, 9);    rd(6'h28, v); chk("R12 watermark", v, 9);
        wr(6'h18, 0);
        // R5 R11 R10: mode 0 loopback, automatic select
        set_mode(0, 0);
        send(8'hA5); send(8'h3C); send(8'hF0);
        repeat (10) @(negedge clk);
        chk("R11 select while busy", {28'd0, ss_n}, 32'hE);
        wait_tog(48);
        chk("R11 select when idle", {28'd0, ss_n}, 32'hF);
        chk("R5 edge count", tog, 48);
        chk("R2 half period code1", min_iv, 2);
        chk("R10 back-to-back", max_iv, 2);
        readback(3, "R5 loopback data");
        // R3 other modes, inverted MISO in mode 3
        for (int m = 1; m < 4; m++) begin
            set_mode(m[1], m[0]);
            chk("R3 idle level", {31'd0, sclk}, {31'd0, m[1]});
            miso_inv = (m == 3);
            send(8'h5A + 8'(m)); send(8'h81);
            wait_tog(32);
            chk("R3 edge count", tog, 32);
            readback(2, "R3 receive data");
            miso_inv = 1'b0;
        end
        set_mode(0, 0);
        // R2 divider sweep
        wr(6'h00, 32'h3801 | (3 << 3)); mon_reset();
        send(8'h96); wait_tog(16);
        chk("R2 half period code3 min", min_iv, 8); chk("R2 half period code3 max", max_iv, 8);
        readback(1, "R2 data code3");
        wr(6'h00, 32'h3801); mon_reset();
        send(8'h69); wait_tog(16);
        chk("R2 code0 as code1", max_iv, 2);
        readback(1, "R2 data code0");
        wr(6'h00, 32'h3801 | (7 << 3)); mon_reset();
        send(8'hC3); wait_tog(16);
        chk("R2 half period code7", min_iv, 128);
        readback(1, "R2 data code7");
        wr(6'h00, 32'h3809);
        // R10 inter-byte delay
        wr(6'h18, 6); mon_reset();
        send(8'h11); send(8'h22); send(8'h33);
        wait_tog(48);
        chk("R10 delay gap", max_iv, 8);
        chk("R10 in-byte half", min_iv, 2);
        readback(3, "R10 data");
        wr(6'h18, 0);
        // R4 mode latch on enable
        wr(6'h00, 32'h380B);
        repeat (4) @(negedge clk);
        chk("R4 no effect while enabled", {31'd0, sclk}, 0);
        wr(6'h14, 0); wr(6'h14, 1);
        chk("R4 applied on enable", {31'd0, sclk}, 1);
        wr(6'h00, 32'h3809);
        repeat (2) @(negedge clk);
        chk("R4 held until re-enable", {31'd0, sclk}, 1);
        set_mode(0, 0);
        chk("R4 restored", {31'd0, sclk}, 0);
        // R8 disabled engine holds queued bytes
        wr(6'h14, 0); mon_reset();
        send(8'hDE); send(8'hAD);
        repeat (100) @(negedge clk);
        chk("R8 idle while disabled", tog, 0);
        wr(6'h14, 1);
        wait_tog(32);
        chk("R8 auto start", tog, 32);
        readback(2, "R8 data");
        // R9 manual start
        wr(6'h00, 32'hB809); mon_reset();
        send(8'hBE); send(8'hEF);
        repeat (60) @(negedge clk);
        chk("R9 waits for start", tog, 0);
        wr(6'h00, 32'h1B809);
        rd(6'h00, v); chk("R9 start self-clears", v, 32'hB809);
        wait_tog(32);
        chk("R9 sends whole queue", tog, 32);
        readback(2, "R9 data");
        wr(6'h00, 32'h3809);
        // R6 empty receive read
        rd(6'h20, v); chk("R6 empty read", v, 0);
        rd(6'h20, v); chk("R6 empty read again", v, 0);
        mon_reset();
        send(8'h77); wait_tog(16);
        readback(1, "R6 pointer unchanged");
        // R7 transmit overflow
        wr(6'h14, 0); mon_reset();
        for (int i = 0; i < DEPTH + 2; i++) begin
            if (i < DEPTH) send(8'h40 + 8'(i));
            else wr(6'h1C, 32'hEE);
        end
        wr(6'h14, 1);
        wait_tog(16 * DEPTH + 16);
        chk("R7 overflow dropped", tog, 16 * DEPTH);
        readback(DEPTH, "R7 data");
        rd(6'h20, v); chk("R7 nothing extra received", v, 0);
        // R11 forced and decoded selects
        wr(6'h14, 0);
        wr(6'h00, 32'h6C09);
        chk("R11 forced select", {28'd0, ss_n}, 32'hB);
        wr(6'h00, 32'h4A09);
        chk("R11 decoded index", {28'd0, ss_n}, 32'h2);
        rd(6'h00, v); chk("R11 decoded flag readback", v, 32'h4A09);
        chk("R3 scoreboard drained", exp_mosi.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule